// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Self Refresh

This block keeps an asynchronous DRAM's contents alive by issuing refresh cycles on the row and column strobes. A free-running interval counter marks each refresh that falls due. The owed refreshes are held in a saturating backlog until the access sequencer hands over the strobes. The block supports three refresh methods. Distributed CAS-before-RAS runs one cycle per due interval. Burst CAS-before-RAS waits until several refreshes are owed, then runs them back to back. RAS-only refresh presents the block's own row counter on the address bus. The method is read from a configuration input while reset is held.

The block can also put the DRAM into self refresh. It opens a CAS-before-RAS cycle, keeps both strobes low for at least a minimum count, and holds them there for as long as self refresh is requested. On exit it raises both strobes for at least a minimum precharge count. In the burst and RAS-only methods it then refreshes every row in one catch-up run before giving the strobes back. With the distributed method no catch-up is needed.

Arbitration uses a request/grant pair. The block raises its request whenever it has work. The sequencer answers with a grant and keeps it until the request falls. The strobes move only while the grant is high.

Top module: `dram_refresh_sched`

## Requirements
- R1: Every REF_INTERVAL clock cycles one refresh becomes owed. With the distributed method (cfg_method 0, or 3, which is treated the same) and a prompt grant, one CAS-before-RAS cycle is run for each owed refresh, with one grant per cycle.
- R2: Owed refreshes are counted in a backlog that stops at BACKLOG_MAX. While the grant is withheld, no owed refresh is lost up to that limit, and none beyond it is kept.
- R3: In a CAS-before-RAS cycle, cas_n is already low in the cycle before ras_n falls. ras_n stays low for T_RAS cycles, and both strobes then stay high for T_RP cycles.
- R4: In a RAS-only cycle, cas_n stays high and row_addr carries the row being refreshed when ras_n falls. The row counter starts at 0 after reset and steps by one, modulo ROWS, after each such cycle.
- R5: With the burst method (cfg_method 1), no request is raised until BURST_LEN refreshes are owed. Then all owed refreshes run back to back under a single grant.
- R6: ref_req is high whenever the block has work. Neither strobe is low unless ref_gnt is high. ref_req stays high until the last strobe activity of the sequence has ended. After reset both strobes are high, ref_req and sr_active are low, and row_addr is 0.
- R7: While sr_req is high, the block enters self refresh once granted: a CAS-before-RAS cycle whose strobes stay low, with sr_active high. Strobes stay low for at least T_SR_LOW cycles, even if sr_req drops sooner, and for as long as sr_req stays high.
- R8: On leaving self refresh, both strobes stay high for at least T_SR_EXIT cycles before ras_n falls again.
- R9: After self refresh, the burst method runs REFS_PER_PERIOD CAS-before-RAS cycles and the RAS-only method (cfg_method 2) runs ROWS RAS-only cycles, all under the same grant. The distributed method runs none. The backlog is empty when the block releases the strobes.
- R10: If self refresh is requested while refreshes are owed, self refresh is served first and the owed refreshes are discarded.
- R11: cfg_method is read only while rst_n is low. Changing it after reset has no effect on the method used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; cfg_method is captured while low |
| cfg_method | input | 2 | Refresh method: 0 distributed CBR, 1 burst CBR, 2 RAS-only, 3 as 0 |
| sr_req | input | 1 | High to enter and remain in self refresh |
| ref_gnt | input | 1 | Grant of the DRAM strobes from the access sequencer |
| ref_req | output | 1 | Request for the DRAM strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| row_addr | output | $clog2(ROWS) | Row counter, valid for RAS-only cycles |
| sr_active | output | 1 | High while the DRAM is held in self refresh |

## Verification
A self-refresh request and owed periodic refreshes can both be pending in the same cycle the grant arrives. The bench provokes this with the distributed method: it withholds the grant for three intervals so the backlog fills, then raises sr_req and releases the grant together. It judges the outcome by one CAS-before-RAS falling edge with sr_active seen, no further strobe activity, and the request falling afterwards. A second overlap also occurs: an interval tick can land during a catch-up or burst run. The exact counts of falling edges at the ports show whether such a tick leaked in.

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int REF_INTERVAL    = 1953,
  parameter int ROWS            = 8192,
  parameter int REFS_PER_PERIOD = 4096,
  parameter int BURST_LEN       = 8,
  parameter int BACKLOG_MAX     = 16,
  parameter int T_CSR           = 2,
  parameter int T_RAS           = 8,
  parameter int T_RP            = 6,
  parameter int T_SR_LOW        = 12500,
  parameter int T_SR_EXIT       = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               cfg_method,
  input  logic                     sr_req,
  input  logic                     ref_gnt,
  output logic                     ref_req,
  output logic                     ras_n,
  output logic                     cas_n,
  output logic [$clog2(ROWS)-1:0]  row_addr,
  output logic                     sr_active
);

  localparam int RW    = $clog2(ROWS);
  localparam int IW    = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;
  localparam int BW    = $clog2(BACKLOG_MAX + 1);
  localparam int CMAX  = (ROWS > REFS_PER_PERIOD) ? ROWS : REFS_PER_PERIOD;
  localparam int CW    = $clog2(CMAX + 1);
  localparam int TM1   = (T_CSR > T_RAS) ? T_CSR : T_RAS;
  localparam int TM2   = (T_RP > T_SR_EXIT) ? T_RP : T_SR_EXIT;
  localparam int TM3   = (TM1 > TM2) ? TM1 : TM2;
  localparam int TMAX  = (TM3 > T_SR_LOW) ? TM3 : T_SR_LOW;
  localparam int TW    = $clog2(TMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_CSR, S_RAS, S_PRE, S_SRH, S_SRX} state_t;
  typedef enum logic [1:0] {K_CBR, K_ROW, K_SR} kind_t;

  state_t          state;
  kind_t           kind, kind_nxt;
  logic [TW-1:0]   tcnt;
  logic [IW-1:0]   icnt;
  logic [BW-1:0]   backlog;
  logic [CW-1:0]   catch_left;
  logic [RW-1:0]   row_ctr;
  logic [1:0]      method_q;

  logic m_burst, m_row, m_dist, tick, owe, need, more, t_done;
  logic ras_end, bl_dec, bl_clr;
  state_t        start_st;
  logic [TW-1:0] start_t;

  assign m_burst  = (method_q == 2'd1);
  assign m_row    = (method_q == 2'd2);
  assign m_dist   = !m_burst && !m_row;
  assign tick     = (icnt == IW'(REF_INTERVAL - 1));
  assign owe      = m_burst ? (backlog >= BW'(BURST_LEN)) : (backlog != '0);
  assign need     = sr_req || (catch_left != '0) || owe;
  assign more     = sr_req || (catch_left != '0) || (m_burst && backlog != '0);
  assign t_done   = (tcnt == '0);
  assign kind_nxt = sr_req ? K_SR : (m_row ? K_ROW : K_CBR);
  assign start_st = (kind_nxt == K_ROW) ? S_RAS : S_CSR;
  assign start_t  = (kind_nxt == K_ROW) ? TW'(T_RAS - 1) : TW'(T_CSR - 1);
  assign ras_end  = (state == S_RAS) && t_done;
  assign bl_dec   = ras_end && (catch_left == '0) && (backlog != '0);
  assign bl_clr   = (state == S_SRH) || (state == S_SRX) ||
                    (ras_end && catch_left == CW'(1));

  assign ref_req   = (state != S_IDLE);
  assign sr_active = (state == S_SRH);
  assign ras_n     = !((state == S_RAS) || (state == S_SRH));
  assign cas_n     = !((state == S_CSR) || (state == S_SRH) ||
                       ((state == S_RAS) && (kind != K_ROW)));
  assign row_addr  = row_ctr;

  always_ff @(posedge clk) begin
    if (!rst_n) icnt <= '0;
    else        icnt <= tick ? '0 : icnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || bl_clr)
      backlog <= '0;
    else if (tick && !bl_dec && backlog != BW'(BACKLOG_MAX))
      backlog <= backlog + 1'b1;
    else if (bl_dec && !tick)
      backlog <= backlog - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      kind       <= K_CBR;
      tcnt       <= '0;
      catch_left <= '0;
      row_ctr    <= '0;
      method_q   <= cfg_method;
    end else begin
      case (state)
        S_IDLE: if (need) state <= S_REQ;
        S_REQ: begin
          if (!need) state <= S_IDLE;
          else if (ref_gnt) begin
            kind  <= kind_nxt;
            state <= start_st;
            tcnt  <= start_t;
          end
        end
        S_CSR: begin
          if (!t_done) tcnt <= tcnt - 1'b1;
          else if (kind == K_SR) begin
            state <= S_SRH;
            tcnt  <= TW'(T_SR_LOW - 1);
          end else begin
            state <= S_RAS;
            tcnt  <= TW'(T_RAS - 1);
          end
        end
        S_RAS: begin
          if (!t_done) tcnt <= tcnt - 1'b1;
          else begin
            state <= S_PRE;
            tcnt  <= TW'(T_RP - 1);
            if (kind == K_ROW)
              row_ctr <= (row_ctr == RW'(ROWS - 1)) ? '0 : row_ctr + 1'b1;
            if (catch_left != '0) catch_left <= catch_left - 1'b1;
          end
        end
        S_PRE: begin
          if (!t_done) tcnt <= tcnt - 1'b1;
          else if (more) begin
            kind  <= kind_nxt;
            state <= start_st;
            tcnt  <= start_t;
          end else state <= S_IDLE;
        end
        S_SRH: begin
          if (!t_done) tcnt <= tcnt - 1'b1;
          else if (!sr_req) begin
            state <= S_SRX;
            tcnt  <= TW'(T_SR_EXIT - 1);
          end
        end
        S_SRX: begin
          if (!t_done) tcnt <= tcnt - 1'b1;
          else begin
            if (!m_dist) catch_left <= m_row ? CW'(ROWS) : CW'(REFS_PER_PERIOD);
            if (!m_dist || sr_req) begin
              kind  <= kind_nxt;
              state <= start_st;
              tcnt  <= start_t;
            end else state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  localparam int LW = TW + 1;
  logic [LW-1:0] low_cnt, hi_cnt;
  logic          after_sr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      hi_cnt   <= '0;
      after_sr <= 1'b0;
    end else begin
      low_cnt  <= ras_n ? '0 : ((low_cnt == '1) ? low_cnt : low_cnt + 1'b1);
      hi_cnt   <= !ras_n ? '0 : ((hi_cnt == '1) ? hi_cnt : hi_cnt + 1'b1);
      if (sr_active) after_sr <= 1'b1;
      else if (!ras_n) after_sr <= 1'b0;
    end
  end

  // R6
  strobe_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n) |-> (ref_gnt && ref_req));

  // R3
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> $past(!cas_n));

  // R4
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ras_n) && $past(cas_n)) |->
      (row_addr == (($past(row_addr) == RW'(ROWS - 1)) ? '0 : $past(row_addr) + 1'b1)));

  // R7
  sr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ras_n) && $past(sr_active)) |-> (low_cnt >= LW'(T_SR_LOW)));

  // R8
  sr_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && after_sr) |-> (hi_cnt >= LW'(T_SR_EXIT)));

endmodule

// File: tb/tb_dram_refresh_sched.sv
`timescale 1ns/1ps
module tb_dram_refresh_sched;
  localparam int REF_INTERVAL = 40;
  localparam int ROWS = 16;
  localparam int REFS = 8;
  localparam int BURST_LEN = 4;
  localparam int BL_MAX = 6;
  localparam int T_SR_LOW = 10;
  localparam int T_SR_EXIT = 4;

  logic clk = 0, rst_n = 0, sr_req = 0, ref_gnt = 0, gnt_en = 0;
  logic [1:0] cfg_method = 0;
  logic ref_req, ras_n, cas_n, sr_active;
  logic [3:0] row_addr;

  int checks = 0, failures = 0;
  int cbr_cnt, row_cnt, req_rise, exp_row, low_run, hi_run, max_low, hi_after_sr;
  logic sr_flag, sr_seen, prev_ras, prev_cas, prev_req, done = 0;

  dram_refresh_sched #(.REF_INTERVAL(REF_INTERVAL), .ROWS(ROWS), .REFS_PER_PERIOD(REFS),
    .BURST_LEN(BURST_LEN), .BACKLOG_MAX(BL_MAX), .T_CSR(1), .T_RAS(3), .T_RP(2),
    .T_SR_LOW(T_SR_LOW), .T_SR_EXIT(T_SR_EXIT)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_method(cfg_method), .sr_req(sr_req), .ref_gnt(ref_gnt),
    .ref_req(ref_req), .ras_n(ras_n), .cas_n(cas_n), .row_addr(row_addr), .sr_active(sr_active));

  always #4 clk = ~clk;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    prev_ras = 1; prev_cas = 1; prev_req = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        cbr_cnt = 0; row_cnt = 0; req_rise = 0; exp_row = 0; low_run = 0; hi_run = 0;
        max_low = 0; hi_after_sr = 0; sr_flag = 0; sr_seen = 0;
      end else begin
        if ((!ras_n || !cas_n) && !ref_gnt) chk(0, "R6 strobe without grant", 0, 1);
        if (prev_ras && !ras_n) begin
          if (sr_flag) begin hi_after_sr = hi_run; sr_flag = 0; end
          hi_run = 0;
          if (!cas_n) begin
            cbr_cnt++;
            chk(!prev_cas, "R3 cas before ras", int'(prev_cas), 0);
          end else begin
            row_cnt++;
            chk(row_addr == 4'(exp_row), "R4 row address", int'(row_addr), exp_row);
            exp_row = (exp_row + 1) % ROWS;
          end
        end
        if (!ras_n) low_run++;
        else begin
          if (!prev_ras && low_run > max_low) max_low = low_run;
          low_run = 0;
          hi_run++;
        end
        if (sr_active) begin sr_seen = 1; sr_flag = 1; end
        if (ref_req && !prev_req) req_rise++;
      end
      prev_ras = ras_n; prev_cas = cas_n; prev_req = ref_req;
      ref_gnt = gnt_en && ref_req;
    end
  end

  task automatic do_reset(input logic [1:0] m);
    rst_n = 0; cfg_method = m; sr_req = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cfg_method = ~m;
  endtask

  task automatic wait_req_drop(input int lim);
    int n = 0, lowc = 0;
    while (!ref_req && n < lim) begin @(negedge clk); n++; end
    while (lowc < 3 && n < lim) begin
      @(negedge clk); n++;
      if (!ref_req) lowc++; else lowc = 0;
    end
    if (n >= lim) chk(0, "R6 request never released", n, lim);
  endtask

  localparam int VEC [4][3] = '{'{0, 10, 0}, '{1, 8, 0}, '{2, 0, 10}, '{3, 10, 0}};

  initial begin
    do_reset(2'd0);
    @(negedge clk);
    chk(ras_n && cas_n, "R6 reset strobes", int'({ras_n, cas_n}), 3);
    chk(!ref_req && !sr_active, "R6 reset req/sr", int'({ref_req, sr_active}), 0);
    chk(row_addr == 0, "R4 reset row", int'(row_addr), 0);

    // R1 R5 R11 vector walk: methods under prompt grant over ten intervals
    foreach (VEC[i]) begin
      gnt_en = 1;
      do_reset(2'(VEC[i][0]));
      repeat (410) @(negedge clk);
      chk(cbr_cnt == VEC[i][1], "R1/R11 CBR count", cbr_cnt, VEC[i][1]);
      chk(row_cnt == VEC[i][2], "R4/R11 RAS-only count", row_cnt, VEC[i][2]);
    end

    // R2 saturation with grant withheld
    gnt_en = 0;
    do_reset(2'd0);
    repeat (12 * REF_INTERVAL + 2) @(negedge clk);
    chk(cbr_cnt == 0 && ref_req, "R6 no cycle without grant", cbr_cnt, 0);
    gnt_en = 1;
    wait_req_drop(400);
    chk(cbr_cnt >= BL_MAX && cbr_cnt <= BL_MAX + 1, "R2 saturated backlog", cbr_cnt, BL_MAX);

    // R5 burst threshold and single grant
    do_reset(2'd1);
    repeat (3 * REF_INTERVAL + 10) @(negedge clk);
    chk(cbr_cnt == 0 && req_rise == 0, "R5 no request below threshold", req_rise, 0);
    repeat (REF_INTERVAL + 20) @(negedge clk);
    chk(cbr_cnt == BURST_LEN, "R5 burst size", cbr_cnt, BURST_LEN);
    chk(req_rise == 1, "R5 one grant per burst", req_rise, 1);

    // R7 R8 R9 self refresh in burst mode with short request
    do_reset(2'd1);
    repeat (5) @(negedge clk);
    sr_req = 1;
    repeat (3) @(negedge clk);
    sr_req = 0;
    wait_req_drop(400);
    chk(sr_seen, "R7 self refresh entered", int'(sr_seen), 1);
    chk(max_low >= T_SR_LOW, "R7 minimum low time", max_low, T_SR_LOW);
    chk(hi_after_sr >= T_SR_EXIT, "R8 exit high time", hi_after_sr, T_SR_EXIT);
    chk(cbr_cnt == 1 + REFS, "R9 burst catch-up", cbr_cnt, 1 + REFS);
    chk(req_rise == 1, "R9 catch-up under one grant", req_rise, 1);

    // R7 R9 self refresh in RAS-only mode with long request
    do_reset(2'd2);
    repeat (2) @(negedge clk);
    sr_req = 1;
    repeat (15) @(negedge clk);
    chk(sr_active && !ras_n && !cas_n, "R7 held while requested", int'(sr_active), 1);
    repeat (5) @(negedge clk);
    sr_req = 0;
    wait_req_drop(400);
    chk(max_low >= 15, "R7 low while requested", max_low, 15);
    chk(row_cnt == ROWS && cbr_cnt == 1, "R9 RAS-only catch-up", row_cnt, ROWS);

    // R10 self refresh and owed refreshes pending at the same grant, distributed
    gnt_en = 0;
    do_reset(2'd0);
    repeat (3 * REF_INTERVAL + 5) @(negedge clk);
    sr_req = 1; gnt_en = 1;
    repeat (4) @(negedge clk);
    sr_req = 0;
    wait_req_drop(200);
    chk(sr_seen && cbr_cnt == 1, "R10 self refresh first, backlog dropped", cbr_cnt, 1);
    chk(!ref_req && row_cnt == 0, "R9 no catch-up in distributed", int'(ref_req), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule